// File: doc/BRIEF.md
# Synchronous Serial Port Controller (master mode)

This block is a memory-mapped synchronous serial port that runs only as a master. Software talks to it over a simple register bus with write and read strobes, a byte address and a data word. Words written to the data register go into an 8-entry transmit queue. A transfer engine takes them out one at a time and hands each one to a full-duplex word exchange port, or loops it straight back internally. The word that comes back is placed in an 8-entry receive queue, which software drains by reading the same data register.

The exchange port uses a valid/ready handshake with at most one word in flight. The offered word stays at the head of the transmit queue until the peer accepts it. The returned word is stored in the receive queue in the same cycle. The engine never overruns the receive queue: it waits while that queue is full.

Status flags, two level-sensitive interrupt sources at the half-full marks, a mask register and one interrupt line let software pace the traffic. A fixed set of identification bytes sits at the top of the address window. Bus read data is combinational and valid in the same cycle as `bus_rd`. A read of the data register removes the word at the clock edge.

Top module: `ssp_ctrl`

## Requirements
- R1: Each queue holds 8 words. A data-register write (word offset 0x08) is dropped when the transmit queue already holds 8 words. Entries leave in the order they were written.
- R2: The frame size is cfg0[3:0] + 1 bits. A word is cut to that width when it enters the transmit queue, and again when it enters the receive queue. Each cut uses the setting in force at that moment.
- R3: A read of the data register returns the oldest received word and removes it. When the receive queue is empty, the read returns 0 and changes nothing.
- R4: The status register at 0x0C reads {busy, rx full, rx not empty, tx not full, tx empty} in bits 4..0. Busy means the transmit queue is not empty. After reset it reads 0x03.
- R5: Raw interrupt status at 0x18 has bit 2 set when the receive queue holds 4 or more words and bit 3 set when the transmit queue holds 4 or fewer; bits 1:0 read 0. The masked view at 0x1C is raw AND mask (mask at 0x14, 4 bits). `irq` is high when the masked view is non-zero. After reset, raw reads 0x08.
- R6: The engine moves words only when cfg1 bit 1 (enable) is 1 and cfg1 bit 2 (slave select) is 0. It moves at most one word per cycle, and only while the transmit queue is not empty and the receive queue is not full.
- R7: With cfg1 bit 0 (loopback) set, each transmitted word becomes the received word and `xchg_valid` stays low. Otherwise `xchg_valid` offers the head word on `xchg_tx_word`, holding it unchanged until `xchg_ready`. On that cycle the word is popped and `xchg_rx_word` is stored.
- R8: cfg0 (0x00, 16 bits), cfg1 (0x04, 4 bits), prescaler (0x10, 8 bits) and mask read back what was written. A write to 0x20 has no effect and 0x20 reads 0. Unmapped offsets read 0.
- R9: Offsets 0xFE0 to 0xFFC read, one byte per word, 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops data on data offset) |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Level interrupt, any masked raw bit set |
| xchg_valid | output | 1 | Word offered to the exchange peer |
| xchg_tx_word | output | 16 | Offered word |
| xchg_ready | input | 1 | Peer accepts and returns a word this cycle |
| xchg_rx_word | input | 16 | Word returned by the peer |

## Verification
Two pairs of events can land in the same cycle. A bus push into the transmit queue can coincide with an engine pop from it. A bus pop from the receive queue can coincide with an engine push into it. Both are provoked by random interleaving of data writes and reads while the engine runs against a randomly stalling peer. The bench polls status before each access, so every write it makes is known to be accepted and every read is known to find data. It then compares each received word, in order, against the peer transform of the cut transmit word. A directed case fills the receive queue and keeps writing, to show the engine stalls and then resumes one word per freed slot without losing or reordering data.

// File: rtl/ssp_pkg.sv
// Shared constants and helpers for the serial port controller.
// Assumes a 12-bit byte address bus with word-aligned accesses.
package ssp_pkg;
    localparam int BUS_AW = 12;
    localparam int WSEL_W = BUS_AW - 2;

    // Word-select values (byte offset >> 2)
    localparam logic [WSEL_W-1:0] REG_CFG0 = 10'h000;
    localparam logic [WSEL_W-1:0] REG_CFG1 = 10'h001;
    localparam logic [WSEL_W-1:0] REG_DATA = 10'h002;
    localparam logic [WSEL_W-1:0] REG_STAT = 10'h003;
    localparam logic [WSEL_W-1:0] REG_PRE  = 10'h004;
    localparam logic [WSEL_W-1:0] REG_MASK = 10'h005;
    localparam logic [WSEL_W-1:0] REG_RAW  = 10'h006;
    localparam logic [WSEL_W-1:0] REG_MIS  = 10'h007;

    // Control register 1 layout; bit order is software-visible
    typedef struct packed {
        logic out_off;   // bit 3
        logic slave;     // bit 2
        logic enable;    // bit 1
        logic loopback;  // bit 0
    } cfg1_t;

    // Identification byte for word index i in the ID window
    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0: id_byte = 8'h22;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h04;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/ssp_fifo.sv
// Circular word queue with occupancy count.
// Assumes the caller never pushes when full nor pops when empty;
// a simultaneous push and pop keeps the count unchanged.
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        nxt = (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[wp] <= wdata;
        end
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    assign head = mem[rp];
endmodule

// File: rtl/ssp_xfer.sv
// Transfer engine: decides each cycle whether the head transmit word
// moves, either by internal loopback or through the valid/ready
// exchange port. Purely combinational; the word stays in the transmit
// queue until it is accepted, so no holding register is needed.
module ssp_xfer #(
    parameter int DATA_W = 16
) (
    input  logic              run,
    input  logic              loopback,
    input  logic              tx_avail,
    input  logic              rx_space,
    input  logic [DATA_W-1:0] tx_head,
    input  logic [DATA_W-1:0] fmask,
    input  logic              xchg_ready,
    input  logic [DATA_W-1:0] xchg_rx_word,
    output logic              xchg_valid,
    output logic [DATA_W-1:0] xchg_tx_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word
);
    logic go;

    // Move decision and returned-word selection
    always_comb begin
        go           = run && tx_avail && rx_space;
        xchg_valid   = go && !loopback;
        xchg_tx_word = xchg_valid ? tx_head : '0;
        tx_pop       = go && (loopback || xchg_ready);
        rx_push      = tx_pop;
        rx_word      = (loopback ? tx_head : xchg_rx_word) & fmask;
    end
endmodule

// File: rtl/ssp_ctrl.sv
// Master-mode synchronous serial port: register file, two word queues
// and the transfer engine. Assumes single-cycle bus accesses; read data
// is combinational and a data read pops at the clock edge.
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              xchg_valid,
    output logic [DATA_W-1:0] xchg_tx_word,
    input  logic              xchg_ready,
    input  logic [DATA_W-1:0] xchg_rx_word
);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int HALF = DEPTH / 2;

    logic [DATA_W-1:0] cfg0_q;
    cfg1_t             cfg1_q;
    logic [7:0]        pre_q;
    logic [3:0]        mask_q;

    logic [WSEL_W-1:0] wsel;
    logic              id_hit;
    logic [DATA_W:0]   one_sh;
    logic [DATA_W-1:0] fmask;
    logic              wr_data, tx_push, rx_pop, tx_pop, rx_push;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic [4:0]        stat;
    logic [3:0]        raw;
    logic              run_on, lb_on;

    // Address decode and queue strobes
    always_comb begin
        wsel    = bus_addr[BUS_AW-1:2];
        id_hit  = (bus_addr[BUS_AW-1:5] == 7'h7F);
        wr_data = bus_wr && (wsel == REG_DATA);
        tx_push = wr_data && (tx_cnt != CW'(DEPTH));
        rx_pop  = bus_rd && (wsel == REG_DATA) && (rx_cnt != '0);
        run_on  = cfg1_q.enable && !cfg1_q.slave;
        lb_on   = cfg1_q.loopback;
    end

    // Frame-width mask from cfg0[3:0]
    always_comb begin
        one_sh = (DATA_W+1)'(1) << ({1'b0, cfg0_q[3:0]} + 5'd1);
        fmask  = one_sh[DATA_W-1:0] - DATA_W'(1);
    end

    // Software-visible configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg0_q <= '0;
            cfg1_q <= '0;
            pre_q  <= '0;
            mask_q <= '0;
        end else if (bus_wr && !id_hit) begin
            case (wsel)
                REG_CFG0: cfg0_q <= bus_wdata;
                REG_CFG1: cfg1_q <= cfg1_t'(bus_wdata[3:0]);
                REG_PRE:  pre_q  <= bus_wdata[7:0];
                REG_MASK: mask_q <= bus_wdata[3:0];
                default: ;
            endcase
        end
    end

    ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(bus_wdata & fmask),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt)
    );

    ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt)
    );

    ssp_xfer #(.DATA_W(DATA_W)) u_xfer (
        .run(run_on), .loopback(lb_on),
        .tx_avail(tx_cnt != '0), .rx_space(rx_cnt != CW'(DEPTH)),
        .tx_head(tx_head), .fmask(fmask),
        .xchg_ready(xchg_ready), .xchg_rx_word(xchg_rx_word),
        .xchg_valid(xchg_valid), .xchg_tx_word(xchg_tx_word),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word)
    );

    // Status flags, level interrupt sources and the interrupt line
    always_comb begin
        stat = {tx_cnt != '0, rx_cnt == CW'(DEPTH), rx_cnt != '0,
                tx_cnt != CW'(DEPTH), tx_cnt == '0};
        raw  = {tx_cnt <= CW'(HALF), rx_cnt >= CW'(HALF), 2'b00};
        irq  = |(raw & mask_q);
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (id_hit) begin
            bus_rdata = DATA_W'(id_byte(bus_addr[4:2]));
        end else begin
            case (wsel)
                REG_CFG0: bus_rdata = cfg0_q;
                REG_CFG1: bus_rdata = DATA_W'(cfg1_q);
                REG_DATA: bus_rdata = (rx_cnt != '0) ? rx_head : '0;
                REG_STAT: bus_rdata = DATA_W'(stat);
                REG_PRE:  bus_rdata = DATA_W'(pre_q);
                REG_MASK: bus_rdata = DATA_W'(mask_q);
                REG_RAW:  bus_rdata = DATA_W'(raw);
                REG_MIS:  bus_rdata = DATA_W'(raw & mask_q);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ssp_ctrl_chk.sv
// Property checker for ssp_ctrl, attached by bind. Observes queue
// occupancy, engine strobes and the exchange handshake.
module ssp_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       wr_data,
    input logic                       tx_pop,
    input logic                       rx_push,
    input logic                       run_on,
    input logic                       lb_on,
    input logic                       xchg_valid,
    input logic                       xchg_ready,
    input logic [DATA_W-1:0]          xchg_tx_word,
    input logic [3:0]                 mask_q,
    input logic                       irq
);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int HALF = DEPTH / 2;

    // R1: occupancy never exceeds the depth
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    // R1: a write into a full queue with no pop leaves it full
    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_cnt == CW'(DEPTH) && !tx_pop) |=> (tx_cnt == CW'(DEPTH)));

    // R6: no receive push while the receive queue is full
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CW'(DEPTH)) |-> !rx_push);

    // R6: engine idle unless enabled in master mode
    p_idle_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_on |-> (!tx_pop && !xchg_valid));

    // R7: loopback keeps the exchange port quiet
    p_loop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lb_on |-> !xchg_valid);

    // R7: an offered word is held until accepted
    p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_valid && !xchg_ready) |=> (!xchg_valid || $stable(xchg_tx_word)));

    // R5: receive half-full with its mask bit drives the line
    p_rx_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt >= CW'(HALF) && mask_q[2]) |-> irq);

    // R5: nothing masked in, line low
    p_quiet_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'h0) |-> !irq);
endmodule

bind ssp_ctrl ssp_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .wr_data(wr_data), .tx_pop(tx_pop), .rx_push(rx_push),
    .run_on(run_on), .lb_on(lb_on), .xchg_valid(xchg_valid),
    .xchg_ready(xchg_ready), .xchg_tx_word(xchg_tx_word),
    .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_ssp_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random
// interleaving of data writes and reads against a stalling peer.
module tb_ssp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [11:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        irq, xchg_valid, xchg_ready;
    logic [15:0] xchg_tx_word, xchg_rx_word;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] exp_q[$];
    logic [15:0] wv[11];

    ssp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .xchg_valid(xchg_valid), .xchg_tx_word(xchg_tx_word),
        .xchg_ready(xchg_ready), .xchg_rx_word(xchg_rx_word)
    );

    always #10 clk = ~clk;

    // Peer: returns a byte-swapped, scrambled copy of the offered word
    function automatic logic [15:0] peer(input logic [15:0] x);
        peer = {x[7:0], x[15:8]} ^ 16'h3C96;
    endfunction
    assign xchg_rx_word = peer(xchg_tx_word);

    function automatic logic [15:0] fm(input int fs);
        fm = 16'((32'h1 << (fs + 1)) - 1);
    endfunction

    // Random acceptance by the peer
    always @(negedge clk) xchg_ready <= (($urandom % 3) != 0);

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int fsz;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        brd(12'h00C, d); check("R4", "reset status", d, 16'h0003);
        brd(12'h018, d); check("R5", "reset raw", d, 16'h0008);
        check("R5", "reset irq", {15'b0, irq}, 16'h0000);
        bwr(12'h014, 16'h0008);
        check("R5", "tx-low irq", {15'b0, irq}, 16'h0001);
        brd(12'h01C, d); check("R5", "masked tx-low", d, 16'h0008);
        bwr(12'h014, 16'h0000);

        // Register map and ID window
        bwr(12'h000, 16'hBEE7); brd(12'h000, d); check("R8", "cfg0", d, 16'hBEE7);
        bwr(12'h004, 16'h0009); brd(12'h004, d); check("R8", "cfg1", d, 16'h0009);
        bwr(12'h004, 16'h0000);
        bwr(12'h010, 16'h1FF);  brd(12'h010, d); check("R8", "prescaler", d, 16'h00FF);
        bwr(12'h014, 16'h0004); brd(12'h014, d); check("R8", "mask", d, 16'h0004);
        bwr(12'h020, 16'h0003); brd(12'h020, d); check("R8", "dma reads 0", d, 16'h0000);
        brd(12'h00C, d); check("R8", "dma no effect", d, 16'h0003);
        brd(12'h024, d); check("R8", "unmapped", d, 16'h0000);
        begin
            logic [7:0] ids[8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            for (int i = 0; i < 8; i++) begin
                brd(12'hFE0 + 12'(i * 4), d);
                check("R9", "id byte", d, {8'h00, ids[i]});
            end
        end

        // Fill while disabled, with thresholds and drop on full
        bwr(12'h000, 16'h0007);
        for (int i = 0; i < 10; i++) begin
            wv[i] = 16'($urandom);
            bwr(12'h008, wv[i]);
            if (i == 3) begin brd(12'h018, d); check("R5", "tx count 4", d, 16'h0008); end
            if (i == 4) begin brd(12'h018, d); check("R5", "tx count 5", d, 16'h0000); end
        end
        brd(12'h00C, d); check("R4", "tx full", d, 16'h0010);
        bwr(12'h004, 16'h0003);
        idle(10);
        brd(12'h00C, d); check("R4", "rx full tx empty", d, 16'h000F);
        brd(12'h018, d); check("R5", "raw both", d, 16'h000C);
        check("R5", "rx irq", {15'b0, irq}, 16'h0001);
        brd(12'h01C, d); check("R5", "masked rx", d, 16'h0004);
        for (int k = 0; k < 8; k++) begin
            brd(12'h008, d); check("R1", "loop order/drop", d, wv[k] & 16'h00FF);
            if (k == 3) begin brd(12'h018, d); check("R5", "rx count 4", d, 16'h000C); end
            if (k == 4) begin brd(12'h018, d); check("R5", "rx count 3", d, 16'h0008); end
        end
        brd(12'h008, d); check("R3", "empty read", d, 16'h0000);
        brd(12'h00C, d); check("R3", "empty read no change", d, 16'h0003);
        check("R5", "irq low", {15'b0, irq}, 16'h0000);

        // Stall on full receive queue
        bwr(12'h004, 16'h0000);
        for (int i = 0; i < 11; i++) wv[i] = 16'($urandom);
        for (int i = 0; i < 8; i++) bwr(12'h008, wv[i]);
        bwr(12'h004, 16'h0003);
        idle(10);
        for (int i = 8; i < 11; i++) bwr(12'h008, wv[i]);
        idle(3);
        brd(12'h00C, d); check("R6", "stalled", d, 16'h001E);
        brd(12'h008, d); check("R6", "stall first", d, wv[0] & 16'h00FF);
        idle(3);
        brd(12'h00C, d); check("R6", "one slot refilled", d, 16'h001E);
        for (int i = 1; i < 11; i++) begin
            brd(12'h008, d); check("R6", "resume order", d, wv[i] & 16'h00FF);
        end
        brd(12'h00C, d); check("R4", "drained", d, 16'h0003);

        // Width cut at both queue entries
        bwr(12'h004, 16'h0000);
        bwr(12'h000, 16'h000F); bwr(12'h008, 16'hABCD);
        bwr(12'h000, 16'h0003); bwr(12'h004, 16'h0003); idle(3);
        brd(12'h008, d); check("R2", "cut on store", d, 16'h000D);
        bwr(12'h004, 16'h0000); bwr(12'h008, 16'h1234);
        bwr(12'h000, 16'h000F); bwr(12'h004, 16'h0003); idle(3);
        brd(12'h008, d); check("R2", "cut on write", d, 16'h0004);

        // Slave select blocks the engine
        bwr(12'h004, 16'h0006);
        bwr(12'h008, 16'h0111); bwr(12'h008, 16'h0222);
        idle(5);
        brd(12'h00C, d); check("R6", "slave blocks", d, 16'h0012);
        bwr(12'h004, 16'h0003); idle(4);
        brd(12'h008, d); check("R6", "after slave 1", d, 16'h0111);
        brd(12'h008, d); check("R6", "after slave 2", d, 16'h0222);

        // Random exchange traffic at several frame sizes
        bwr(12'h004, 16'h0002);
        for (int ph = 0; ph < 4; ph++) begin
            fsz = (ph == 3) ? 15 : 3 + 4 * ph + int'($urandom % 2);
            bwr(12'h000, 16'(fsz));
            for (int it = 0; it < 200; it++) begin
                logic [15:0] st, w, e;
                brd(12'h00C, st);
                if (($urandom % 2) == 0) begin
                    if (st[1]) begin
                        w = 16'($urandom);
                        bwr(12'h008, w);
                        exp_q.push_back(peer(w & fm(fsz)) & fm(fsz));
                    end
                end else if (st[2]) begin
                    brd(12'h008, d);
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
                    check("R7", "exchange word", d, e);
                end
            end
            for (int t = 0; t < 400 && exp_q.size() > 0; t++) begin
                logic [15:0] st, e;
                brd(12'h00C, st);
                if (st[2]) begin
                    brd(12'h008, d);
                    e = exp_q.pop_front();
                    check("R7", "drain word", d, e);
                end
            end
            check("R7", "all returned", 16'(exp_q.size()), 16'h0000);
            brd(12'h00C, d); check("R4", "idle after phase", d, 16'h0003);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule